// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Fault Flags

This block is a full-duplex SPI engine that moves one byte at a time. A host reaches it through a small register bus with three locations: a control word, a status word and a data word. When the control word selects master operation, a data write loads the shift register and starts a transfer. The block then drives its own serial clock, with a period of a power of two of the system clock. When slave operation is selected, the serial clock and select come from pins. They pass through a synchroniser first, and transfers follow the external master.

The transfer engine is a three-state machine. IDLE moves to RUN on *launch* (master: accepted data write) or *select* (slave: falling select). RUN returns to IDLE on *abort* (master: mode fault; slave: select released), or goes to FINISH on *last edge* (the sixteenth clock edge). FINISH always returns to IDLE on *retire*, and latches the received byte. Three sticky flags report a finished transfer, a rejected data write and a select conflict in master mode. Each flag is cleared by its own two-access sequence.

Top module: `spi_byte_ctrl`

## Requirements
- R1: Bus offsets are 0 control, 1 status, 2 data. Control bit 0 selects master (1) or slave (0), bit 1 is clock polarity, bit 2 is clock phase, bits 5:3 are the rate code. Control and status read 0 after reset.
- R2: With polarity 0, the serial clock output rests low outside a transfer. With polarity 1, it rests high, and it is back at that level when a transfer ends.
- R3: With phase 0, input data is captured on the edge that leaves the idle level. With phase 1, it is captured on the edge that returns to it, and the output bit changes on the other edge.
- R4: In master mode a rate code n from 0 to 6 gives a serial clock period of 2^(n+1) system clocks. With code 7, a data write starts nothing and the serial clock does not move.
- R5: Bytes are shifted most significant bit first, in both directions at once. In master mode a data write starts the transfer, and the received byte is read from offset 2.
- R6: Status bit 0 (done) is set when a transfer completes, and reads 0 during one. It clears only when a status read that sees a flag set is followed by a data access. A data access without that read leaves it set.
- R7: In master mode, a low select input sets status bit 2 (mode fault) and clears control bit 0. The fault clears on a status read followed by a control write.
- R8: A data write while a transfer is running sets status bit 1 (write collision). The write is dropped and the running transfer is unchanged. The flag clears by the same sequence as done.
- R9: In slave mode the block tracks the external clock only while select is low. Clock edges while select is high change neither status nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (read side effects) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| ss_n_i | input | 1 | Active-low slave select in |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |

## Verification
In master mode, a data write sampled on clock edge E0 makes done visible after edge E0 + 16·2^n + 1. The bench reads status without side effects both one cycle before that edge and just after it. A mode fault must show within four clocks of select falling, because select passes through two synchroniser stages and one flag register. Slave transfers are driven with eight system clocks per serial half period, so the three-cycle synchroniser delay always fits inside a half period. Serial bytes captured by the bench-side partner are compared against a queue filled by the driver tasks. All samples are taken at falling system-clock edges.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int DATA_W = 8;
    localparam int RATE_W = 3;
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} xfer_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) - 1;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // half period of the serial clock is 2^rate system clocks
    assign half_m1 = (CNT_W'(1) << rate) - CNT_W'(1);
    assign tick    = en && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic ss_n_pin,
    output logic sck_edge,
    output logic ss_n_s,
    output logic ss_fall
);
    logic [STAGES:0] sck_pipe;
    logic [STAGES:0] ss_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            ss_pipe  <= '1;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_pin};
            ss_pipe  <= {ss_pipe[STAGES-1:0], ss_n_pin};
        end
    end

    assign sck_edge = sck_pipe[STAGES] ^ sck_pipe[STAGES-1];
    assign ss_n_s   = ss_pipe[STAGES-1];
    assign ss_fall  = ss_pipe[STAGES] & ~ss_pipe[STAGES-1];
endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic [RW-1:0] rate_i,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          fault_i,
    input  logic          ss_n_i,
    input  logic          ss_fall_i,
    input  logic          slv_edge_i,
    input  logic          tick_i,
    input  logic          sdi_i,
    output logic          busy_o,
    output logic          run_master_o,
    output logic [RW-1:0] rate_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o,
    output logic          sck_o,
    output logic          sdo_o
);
    localparam int ECNT_W = $clog2(2 * DW);
    localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(2 * DW - 1);

    xfer_state_e state_q, state_d;
    logic              mode_q, cpol_q, cpha_q, sck_act_q;
    logic [RW-1:0]     rate_q;
    logic [ECNT_W-1:0] edge_cnt_q;
    logic [DW-1:0]     tx_sr_q, rx_sr_q, rx_q;
    logic              ev, abort, do_sample, do_shift;

    assign ev        = mode_q ? tick_i : slv_edge_i;
    assign abort     = mode_q ? fault_i : ss_n_i;
    assign do_sample = ev && (edge_cnt_q[0] == cpha_q);
    assign do_shift  = ev && (edge_cnt_q[0] != cpha_q) && !(cpha_q && edge_cnt_q == '0);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (master_i && start_i)        state_d = ST_RUN;  // launch
                else if (!master_i && ss_fall_i) state_d = ST_RUN; // select
            end
            ST_RUN: begin
                if (abort)                             state_d = ST_IDLE;   // abort
                else if (ev && edge_cnt_q == LAST_EDGE) state_d = ST_FINISH; // last edge
            end
            ST_FINISH: state_d = ST_IDLE; // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; rate_q <= '0;
            sck_act_q <= 1'b0; edge_cnt_q <= '0;
            tx_sr_q <= '0; rx_sr_q <= '0; rx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    edge_cnt_q <= '0;
                    if (state_d == ST_RUN) begin
                        mode_q <= master_i;
                        cpol_q <= cpol_i;
                        cpha_q <= cpha_i;
                        rate_q <= rate_i;
                        if (master_i) tx_sr_q <= wdata_i;
                    end else if (load_i) begin
                        tx_sr_q <= wdata_i;
                    end
                end
                ST_RUN: begin
                    if (ev && !abort) begin
                        edge_cnt_q <= edge_cnt_q + ECNT_W'(1);
                        if (mode_q)    sck_act_q <= ~sck_act_q;
                        if (do_sample) rx_sr_q <= {rx_sr_q[DW-2:0], sdi_i};
                        if (do_shift)  tx_sr_q <= {tx_sr_q[DW-2:0], 1'b0};
                    end
                end
                ST_FINISH: rx_q <= rx_sr_q;
                default: ;
            endcase
            if (state_d != ST_RUN) sck_act_q <= 1'b0;
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign run_master_o = (state_q == ST_RUN) && mode_q;
    assign rate_o       = rate_q;
    assign done_o       = (state_q == ST_FINISH);
    assign rx_o         = rx_q;
    assign sck_o        = ((state_q == ST_RUN) ? cpol_q : cpol_i) ^ sck_act_q;
    assign sdo_o        = tx_sr_q[DW-1];

    p_no_reserved_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q) |-> rate_q != '1);
    p_finish_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> $past(state_q) == ST_RUN);
    p_clock_back_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && mode_q) |-> sck_o == cpol_q);
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
    import spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              miso_o
);
    logic              master_q, cpol_q, cpha_q;
    logic [RATE_W-1:0] rate_q, run_rate;
    logic              done_q, wcol_q, modf_q, xfer_arm_q, modf_arm_q;
    logic              ctrl_wr, stat_rd, data_wr, data_acc;
    logic              busy, run_master, tick, fin, sdo, sdi;
    logic              sck_edge, ss_n_s, ss_fall, modf_set, wcol_set, start, load;
    logic [DATA_W-1:0] rx_byte;

    assign ctrl_wr  = bus_sel && bus_wr && bus_addr == OFS_CTRL;
    assign stat_rd  = bus_sel && bus_rd && bus_addr == OFS_STAT;
    assign data_wr  = bus_sel && bus_wr && bus_addr == OFS_DATA;
    assign data_acc = bus_sel && (bus_wr || bus_rd) && bus_addr == OFS_DATA;
    assign wcol_set = data_wr && busy;
    assign start    = data_wr && !busy && master_q && rate_q != '1;
    assign load     = data_wr && !busy && !master_q;
    assign modf_set = master_q && !ss_n_s;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst_n, .sck_pin(sck_i), .ss_n_pin(ss_n_i),
        .sck_edge, .ss_n_s, .ss_fall);

    spi_rate_gen #(.RATE_W(RATE_W)) u_rate (
        .clk, .rst_n, .en(run_master), .rate(run_rate), .tick);

    spi_xfer_fsm #(.DW(DATA_W), .RW(RATE_W)) u_fsm (
        .clk, .rst_n, .master_i(master_q), .cpol_i(cpol_q), .cpha_i(cpha_q),
        .rate_i(rate_q), .start_i(start), .load_i(load), .wdata_i(bus_wdata),
        .fault_i(modf_set), .ss_n_i(ss_n_s), .ss_fall_i(ss_fall),
        .slv_edge_i(sck_edge), .tick_i(tick), .sdi_i(sdi),
        .busy_o(busy), .run_master_o(run_master), .rate_o(run_rate),
        .done_o(fin), .rx_o(rx_byte), .sck_o, .sdo_o(sdo));

    assign sdi    = master_q ? miso_i : mosi_i;
    assign mosi_o = master_q & sdo;
    assign miso_o = ~master_q & sdo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; rate_q <= '0;
            done_q <= 1'b0; wcol_q <= 1'b0; modf_q <= 1'b0;
            xfer_arm_q <= 1'b0; modf_arm_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                master_q <= bus_wdata[0];
                cpol_q   <= bus_wdata[1];
                cpha_q   <= bus_wdata[2];
                rate_q   <= bus_wdata[3 +: RATE_W];
            end
            if (modf_set) master_q <= 1'b0;

            if (stat_rd && (done_q || wcol_q)) xfer_arm_q <= 1'b1;
            else if (data_acc)                 xfer_arm_q <= 1'b0;
            if (stat_rd && modf_q)             modf_arm_q <= 1'b1;
            else if (ctrl_wr)                  modf_arm_q <= 1'b0;

            if (fin)                                 done_q <= 1'b1;
            else if (start || (data_acc && xfer_arm_q)) done_q <= 1'b0;
            if (wcol_set)                   wcol_q <= 1'b1;
            else if (data_acc && xfer_arm_q) wcol_q <= 1'b0;
            if (modf_set)                  modf_q <= 1'b1;
            else if (ctrl_wr && modf_arm_q) modf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {2'b00, rate_q, cpha_q, cpol_q, master_q};
            OFS_STAT: bus_rdata = {5'b0, modf_q, wcol_q, done_q};
            OFS_DATA: bus_rdata = rx_byte;
            default:  bus_rdata = '0;
        endcase
    end

    p_collision_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol_q && busy);
    p_fault_demotes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_q && !ss_n_s) |=> modf_q && !master_q);
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !data_acc) |=> done_q);
endmodule

// File: tb/spi_byte_ctrl_tb_top.sv
module spi_byte_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic sck_o, mosi_o, miso_o, miso_i;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    spi_byte_ctrl dut_i (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
        .bus_rdata, .sck_i, .sck_o, .ss_n_i, .mosi_i, .mosi_o, .miso_i, .miso_o);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // master-side partner model: acts as the external slave
    logic [7:0] m_miso_sr = 8'h00;
    logic [7:0] m_cap = 8'h00;
    int  m_edges = 0, m_samples = 0;
    bit  m_on = 1'b0, m_cpha = 1'b0;
    int  sck_toggles = 0;
    assign miso_i = m_miso_sr[7];

    always @(sck_o) begin
        sck_toggles++;
        if (m_on) begin
            if ((m_edges % 2 == 0) == (m_cpha == 1'b0)) begin
                m_cap = {m_cap[6:0], mosi_o};
                m_samples++;
                if (m_samples == 8) begin
                    if (exp_q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R5 mosi byte actual=%h expected=none", m_cap);
                    end else chk("R5 mosi byte (scoreboard)", m_cap, exp_q.pop_front());
                end
            end else if (!(m_cpha && m_edges == 0)) begin
                m_miso_sr = m_miso_sr << 1;
            end
            m_edges++;
        end
    end

    task automatic arm_model(input bit cpha, input logic [7:0] miso_b, input logic [7:0] mosi_exp);
        m_cpha = cpha; m_miso_sr = miso_b; m_edges = 0; m_samples = 0; m_cap = 0;
        exp_q.push_back(mosi_exp);
        m_on = 1'b1;
    endtask

    // bench acting as external master for slave tests
    task automatic slave_xfer(input logic [7:0] b, input bit cpha);
        logic [7:0] cap = 8'h00;
        if (!cpha) mosi_i = b[7];
        for (int e = 0; e < 16; e++) begin
            repeat (8) @(negedge clk);
            sck_i = ~sck_i;
            if ((e % 2 == 0) == !cpha) cap = {cap[6:0], miso_o};
            else begin
                int idx = cpha ? 7 - e / 2 : 7 - (e + 1) / 2;
                if (idx >= 0) mosi_i = b[idx];
            end
        end
        if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 miso byte actual=%h expected=none", cap);
        end else chk("R9 miso byte (scoreboard)", cap, exp_q.pop_front());
    endtask

    task automatic master_xfer(input logic [7:0] ctrl, input int half,
                               input logic [7:0] tx, input logic [7:0] rx_exp, input string tag);
        logic [7:0] v;
        arm_model(ctrl[2], rx_exp, tx);
        bus_write(2'd2, tx);
        repeat (16 * half) @(posedge clk);
        @(negedge clk);
        peek(2'd1, v); chk({tag, " R6 done low in flight"}, v & 8'h01, 8'h00);
        @(posedge clk);
        @(negedge clk);
        peek(2'd1, v); chk({tag, " R5 done due"}, v, 8'h01);
        m_on = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
        peek(2'd1, v); chk("R6 status reset", v, 8'h00);
        chk("R2 sck idle low", {7'b0, sck_o}, 8'h00);

        // master, polarity 0 phase 0, rate 0 (half period 1)
        bus_write(2'd0, 8'h01);
        master_xfer(8'h01, 1, 8'hA5, 8'h3C, "mode0");
        bus_read(2'd1, v);
        bus_read(2'd2, v); chk("R5 rx byte mode0", v, 8'h3C);
        peek(2'd1, v); chk("R6 cleared by sequence", v, 8'h00);

        // master, polarity 1 phase 1, rate 2 (half period 4)
        bus_write(2'd0, 8'h17);
        @(negedge clk);
        chk("R2 sck idle high", {7'b0, sck_o}, 8'h01);
        master_xfer(8'h17, 4, 8'h96, 8'h5A, "mode3 R3 R4");
        chk("R2 sck back high", {7'b0, sck_o}, 8'h01);
        bus_read(2'd2, v); chk("R5 rx byte mode3", v, 8'h5A);
        peek(2'd1, v); chk("R6 data read alone keeps done", v, 8'h01);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        peek(2'd1, v); chk("R6 cleared after status read", v, 8'h00);

        // write collision, rate 1
        bus_write(2'd0, 8'h09);
        arm_model(1'b0, 8'hE7, 8'h5A);
        bus_write(2'd2, 8'h5A);
        repeat (10) @(negedge clk);
        bus_write(2'd2, 8'hFF);
        repeat (40) @(negedge clk);
        m_on = 1'b0;
        peek(2'd1, v); chk("R8 collision flag", v, 8'h03);
        bus_read(2'd1, v);
        bus_read(2'd2, v); chk("R8 transfer unaffected", v, 8'hE7);
        peek(2'd1, v); chk("R8 collision cleared", v, 8'h00);

        // reserved rate code
        bus_write(2'd0, 8'h39);
        sck_toggles = 0;
        bus_write(2'd2, 8'h11);
        repeat (300) @(negedge clk);
        peek(2'd1, v); chk("R4 code 7 starts nothing", v, 8'h00);
        chk("R4 code 7 sck still", 8'(sck_toggles), 8'h00);

        // mode fault
        bus_write(2'd0, 8'h01);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R7 master bit cleared", v, 8'h00);
        peek(2'd1, v); chk("R7 fault flag", v, 8'h04);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2'd1, v);
        bus_write(2'd0, 8'h01);
        repeat (2) @(negedge clk);
        peek(2'd1, v); chk("R7 fault cleared", v, 8'h00);
        peek(2'd0, v); chk("R7 master restored", v, 8'h01);

        // slave, polarity 0 phase 0
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h81);
        exp_q.push_back(8'h81);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_xfer(8'hC3, 1'b0);
        repeat (10) @(negedge clk);
        peek(2'd1, v); chk("R9 slave done", v, 8'h01);
        bus_read(2'd1, v);
        bus_read(2'd2, v); chk("R9 slave rx mode0", v, 8'hC3);
        ss_n_i = 1'b1;

        // slave, polarity 1 phase 1
        sck_i = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(2'd0, 8'h06);
        bus_write(2'd2, 8'h3C);
        exp_q.push_back(8'h3C);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_xfer(8'hA9, 1'b1);
        repeat (10) @(negedge clk);
        ss_n_i = 1'b1;
        bus_read(2'd1, v);
        bus_read(2'd2, v); chk("R3 slave rx phase 1", v, 8'hA9);
        peek(2'd1, v); chk("R6 slave flags cleared", v, 8'h00);

        // clock activity with select high is ignored
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            repeat (8) @(negedge clk);
            sck_i = ~sck_i;
        end
        repeat (10) @(negedge clk);
        peek(2'd1, v); chk("R9 ignored status", v, 8'h00);
        peek(2'd2, v); chk("R9 ignored data", v, 8'hA9);

        chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule